// File: doc/BRIEF.md
# Complex Vector-Matrix Multiply-Accumulate Engine

This block multiplies a complex vector of N = 2^QUBITS elements by an N×N complex matrix, using a single complex multiply-accumulate datapath, and streams out the N complex results. A run starts with a start pulse. The block then loads the input vector one complex element per accepted cycle into an internal buffer. After that it consumes matrix elements in row-major order through a valid/ready handshake. Element (i, j) is multiplied with stored vector element j and summed into output i.

All arithmetic is signed fixed point. Data words are DATA_W bits with FRAC_W fraction bits. Each product is exact, and the accumulators carry QUBITS guard bits above the widest product sum. Every result is rounded and saturated back to DATA_W bits. Results leave one at a time through a valid/ready output that carries the row index. A one-cycle done pulse follows the acceptance of the final row. Where the matrix comes from does not matter to the block: it may be a lookup memory or a stream.

Top module: `cvm_mac_engine`

## Requirements
- R1: In the load phase, each cycle with vec_valid_i high stores one complex element, in order, at buffer positions 0 to N-1. A cycle with vec_valid_i low stores nothing and does not advance the position. The phase ends after N stored elements.
- R2: out_re_o for index i is the rounded, saturated value of the sum over j of (x_re[j]·m_re[i][j] − x_im[j]·m_im[i][j]).
- R3: out_im_o for index i is the rounded, saturated value of the sum over j of (x_im[j]·m_re[i][j] + x_re[j]·m_im[i][j]).
- R4: Matrix element k accepted in a run belongs to row k/N and column k%N (row-major order). Results appear with out_idx_o = 0, 1, …, N-1 in that order.
- R5: Rounding adds 2^(FRAC_W-1) to the full-precision sum and shifts it arithmetically right by FRAC_W, so halves round toward +infinity. The result is then clamped to [−2^(DATA_W-1), 2^(DATA_W-1)−1].
- R6: A cycle in the compute phase with mat_valid_i low adds nothing, and the partial sum is kept unchanged.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o, out_idx_o, out_re_o and out_im_o hold their values, and mat_ready_o is low.
- R8: done_o is high for exactly one cycle: the cycle after the clock edge at which the result with index N-1 is accepted.
- R9: With vec_valid_i, mat_valid_i and out_ready_i held high, done_o goes high N + N² + 2 clock edges after the edge that samples start_i.
- R10: start_i is ignored while a run is in progress. vec_valid_i is ignored outside the load phase. mat_ready_o is low outside the compute phase.
- R11: After reset, out_valid_o, mat_ready_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when the block is idle |
| vec_valid_i | input | 1 | Vector element present in the load phase |
| vec_re_i | input | DATA_W | Vector element, real part |
| vec_im_i | input | DATA_W | Vector element, imaginary part |
| mat_valid_i | input | 1 | Matrix element present |
| mat_ready_o | output | 1 | Matrix element accepted this cycle if valid |
| mat_re_i | input | DATA_W | Matrix element, real part |
| mat_im_i | input | DATA_W | Matrix element, imaginary part |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Result taken by the consumer |
| out_idx_o | output | QUBITS | Row index of the result |
| out_re_o | output | DATA_W | Result, real part |
| out_im_o | output | DATA_W | Result, imaginary part |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
An identity matrix separates correct column pairing and row order from swapped or transposed indexing, because each output must return its own vector element. A matrix of full-scale values drives both accumulators far past the range, in opposite directions, which exposes a missing clamp or a wrong clamp sign. A half-weight diagonal produces exact half values, some positive and some negative, which pins down the rounding direction. Random vectors and matrices, at full and reduced amplitude, are run with random gaps on the vector and matrix inputs, random output back-pressure and spurious start and vector strobes during compute. These runs separate proper stall handling and hold behaviour from corrupted partial sums. A run with no gaps measures the exact start-to-done latency.

// File: rtl/cvm_pkg.sv
package cvm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_COMP,
    S_DRAIN,
    S_DONE
  } cvm_state_e;
endpackage

// File: rtl/cvm_vec_buf.sv
module cvm_vec_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wre_i,
  input  logic [DW-1:0] wim_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rre_o,
  output logic [DW-1:0] rim_o
);
  logic [DW-1:0] mem_re [DEPTH];
  logic [DW-1:0] mem_im [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_re[waddr_i] <= wre_i;
      mem_im[waddr_i] <= wim_i;
    end
  end

  assign rre_o = mem_re[raddr_i];
  assign rim_o = mem_im[raddr_i];
endmodule

// File: rtl/cvm_ctrl.sv
module cvm_ctrl
  import cvm_pkg::*;
#(
  parameter int QUBITS = 2,
  localparam int N     = 1 << QUBITS,
  localparam int IW    = QUBITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          vec_valid_i,
  input  logic          mat_valid_i,
  input  logic          out_valid_i,
  input  logic          out_ready_i,
  input  logic [IW-1:0] out_idx_i,
  output logic          vec_we_o,
  output logic [IW-1:0] vec_waddr_o,
  output logic          mat_ready_o,
  output logic          fire_o,
  output logic [IW-1:0] col_o,
  output logic [IW-1:0] row_o,
  output logic          first_o,
  output logic          last_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  cvm_state_e    state_q;
  logic [IW-1:0] cnt_q, row_q, col_q;

  assign vec_we_o    = (state_q == S_LOAD) && vec_valid_i;
  assign vec_waddr_o = cnt_q;
  // Block the matrix while a finished row waits for the consumer
  assign mat_ready_o = (state_q == S_COMP) && (!out_valid_i || out_ready_i);
  assign fire_o      = mat_ready_o && mat_valid_i;
  assign col_o       = col_q;
  assign row_o       = row_q;
  assign first_o     = (col_q == '0);
  assign last_o      = (col_q == LAST);
  assign done_o      = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_LOAD;
          cnt_q   <= '0;
        end
        S_LOAD: if (vec_valid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= S_COMP;
            row_q   <= '0;
            col_q   <= '0;
          end
        end
        S_COMP: if (fire_o) begin
          col_q <= col_q + 1'b1;
          if (col_q == LAST) begin
            row_q <= row_q + 1'b1;
            if (row_q == LAST) state_q <= S_DRAIN;
          end
        end
        S_DRAIN: if (out_valid_i && out_ready_i && out_idx_i == LAST) state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && out_ready_i && (out_idx_i == LAST) |=> done_o);

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_ready_in_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_we_o |-> !mat_ready_o);
endmodule

// File: rtl/cvm_cmac.sv
module cvm_cmac #(
  parameter int DW     = 16,
  parameter int FRAC   = 14,
  parameter int QUBITS = 2,
  localparam int IW    = QUBITS,
  localparam int PW    = 2 * DW + 1,
  localparam int AW    = PW + QUBITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic [IW-1:0] row_i,
  input  logic [DW-1:0] x_re_i,
  input  logic [DW-1:0] x_im_i,
  input  logic [DW-1:0] m_re_i,
  input  logic [DW-1:0] m_im_i,
  input  logic          out_ready_i,
  output logic          out_valid_o,
  output logic [IW-1:0] out_idx_o,
  output logic [DW-1:0] out_re_o,
  output logic [DW-1:0] out_im_o
);
  localparam logic signed [AW:0] RND  = (AW + 1)'(1) << (FRAC - 1);
  localparam logic signed [AW:0] MAXV = {{(AW - DW + 2){1'b0}}, {(DW - 1){1'b1}}};
  localparam logic signed [AW:0] MINV = {{(AW - DW + 2){1'b1}}, {(DW - 1){1'b0}}};

  function automatic logic [DW-1:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW:0] t;
    t = $signed({a[AW-1], a}) + RND;
    t = t >>> FRAC;
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DW-1:0];
  endfunction

  logic signed [PW-1:0] xr, xi, mr, mi, prod_re, prod_im;
  assign xr = PW'($signed(x_re_i));
  assign xi = PW'($signed(x_im_i));
  assign mr = PW'($signed(m_re_i));
  assign mi = PW'($signed(m_im_i));
  assign prod_re = xr * mr - xi * mi;
  assign prod_im = xi * mr + xr * mi;

  // Product stage
  logic                 p_valid, p_first, p_last;
  logic [IW-1:0]        p_row;
  logic signed [PW-1:0] p_re, p_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid <= 1'b0;
      p_first <= 1'b0;
      p_last  <= 1'b0;
      p_row   <= '0;
      p_re    <= '0;
      p_im    <= '0;
    end else begin
      p_valid <= fire_i;
      if (fire_i) begin
        p_first <= first_i;
        p_last  <= last_i;
        p_row   <= row_i;
        p_re    <= prod_re;
        p_im    <= prod_im;
      end
    end
  end

  // Accumulate stage
  logic signed [AW-1:0] acc_re, acc_im, sum_re, sum_im;
  assign sum_re = (p_first ? AW'(0) : acc_re) + AW'(p_re);
  assign sum_im = (p_first ? AW'(0) : acc_im) + AW'(p_im);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (p_valid) begin
      acc_re <= sum_re;
      acc_im <= sum_im;
    end
  end

  // Result holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else if (p_valid && p_last) begin
      out_valid_o <= 1'b1;
      out_idx_o   <= p_row;
      out_re_o    <= round_sat(sum_re);
      out_im_o    <= round_sat(sum_im);
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_hold_on_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_valid |=> $stable(acc_re) && $stable(acc_im));

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_idx_o)
                                    && $stable(out_re_o) && $stable(out_im_o));
endmodule

// File: rtl/cvm_mac_engine.sv
module cvm_mac_engine #(
  parameter int QUBITS = 2,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14,
  localparam int N     = 1 << QUBITS,
  localparam int IW    = QUBITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vec_valid_i,
  input  logic [DATA_W-1:0] vec_re_i,
  input  logic [DATA_W-1:0] vec_im_i,
  input  logic              mat_valid_i,
  output logic              mat_ready_o,
  input  logic [DATA_W-1:0] mat_re_i,
  input  logic [DATA_W-1:0] mat_im_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [IW-1:0]     out_idx_o,
  output logic [DATA_W-1:0] out_re_o,
  output logic [DATA_W-1:0] out_im_o,
  output logic              done_o
);
  logic              vec_we, fire, first, last;
  logic [IW-1:0]     vec_waddr, col, row;
  logic [DATA_W-1:0] x_re, x_im;

  cvm_ctrl #(.QUBITS(QUBITS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .vec_valid_i (vec_valid_i),
    .mat_valid_i (mat_valid_i),
    .out_valid_i (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_idx_i   (out_idx_o),
    .vec_we_o    (vec_we),
    .vec_waddr_o (vec_waddr),
    .mat_ready_o (mat_ready_o),
    .fire_o      (fire),
    .col_o       (col),
    .row_o       (row),
    .first_o     (first),
    .last_o      (last),
    .done_o      (done_o)
  );

  cvm_vec_buf #(.DW(DATA_W), .DEPTH(N)) u_buf (
    .clk_i   (clk_i),
    .we_i    (vec_we),
    .waddr_i (vec_waddr),
    .wre_i   (vec_re_i),
    .wim_i   (vec_im_i),
    .raddr_i (col),
    .rre_o   (x_re),
    .rim_o   (x_im)
  );

  cvm_cmac #(.DW(DATA_W), .FRAC(FRAC_W), .QUBITS(QUBITS)) u_cmac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .first_i     (first),
    .last_i      (last),
    .row_i       (row),
    .x_re_i      (x_re),
    .x_im_i      (x_im),
    .m_re_i      (mat_re_i),
    .m_im_i      (mat_im_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_idx_o   (out_idx_o),
    .out_re_o    (out_re_o),
    .out_im_o    (out_im_o)
  );
endmodule

// File: tb/cvm_mac_engine_bench.sv
module cvm_mac_engine_bench;
  localparam int QB = 2;
  localparam int DW = 16;
  localparam int FR = 14;
  localparam int N  = 1 << QB;
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          vec_valid = 1'b0;
  logic [DW-1:0] vec_re = '0, vec_im = '0;
  logic          mat_valid = 1'b0;
  logic          mat_ready;
  logic [DW-1:0] mat_re = '0, mat_im = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [QB-1:0] out_idx;
  logic [DW-1:0] out_re, out_im;
  logic          done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int vr[N], vi[N], mr[NN], mi[NN];

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cvm_mac_engine #(.QUBITS(QB), .DATA_W(DW), .FRAC_W(FR)) u_cvm_mac_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .vec_valid_i(vec_valid), .vec_re_i(vec_re), .vec_im_i(vec_im),
    .mat_valid_i(mat_valid), .mat_ready_o(mat_ready),
    .mat_re_i(mat_re), .mat_im_i(mat_im),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_idx_o(out_idx),
    .out_re_o(out_re), .out_im_o(out_im), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd_sat(input longint s);
    longint t;
    t = (s + (longint'(1) <<< (FR - 1))) >>> FR;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  function automatic int exp_re(input int i);
    longint s = 0;
    for (int j = 0; j < N; j++)
      s += longint'(vr[j]) * mr[i*N+j] - longint'(vi[j]) * mi[i*N+j];
    return rnd_sat(s);
  endfunction

  function automatic int exp_im(input int i);
    longint s = 0;
    for (int j = 0; j < N; j++)
      s += longint'(vi[j]) * mr[i*N+j] + longint'(vr[j]) * mi[i*N+j];
    return rnd_sat(s);
  endfunction

  function automatic int rval(input int shift);
    return int'($signed(16'($urandom))) >>> shift;
  endfunction

  // gaps: random stalls, back-pressure and spurious strobes; else full rate
  task automatic run_case(input bit gaps, input bit chk_lat);
    int c0, j, k, eo, steps;
    bit prev_last, pend, seen_done;
    logic [DW-1:0] h_re, h_im;
    logic [QB-1:0] h_idx;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    j = 0;
    while (j < N) begin
      vec_valid = gaps ? 1'($urandom_range(0, 1)) : 1'b1;
      vec_re = DW'(vr[j]);
      vec_im = DW'(vi[j]);
      mat_valid = 1'b1;
      #1;
      chk(mat_ready == 1'b0, "R10", "mat_ready during load", mat_ready, 0);
      @(negedge clk);
      if (vec_valid) j++;
    end
    mat_valid = 1'b0;
    k = 0; eo = 0; steps = 0;
    prev_last = 1'b0; pend = 1'b0; seen_done = 1'b0;
    while (!seen_done && steps < 2000) begin
      steps++;
      out_ready = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
      mat_valid = (k < NN) && (gaps ? ($urandom_range(0, 3) != 0) : 1'b1);
      mat_re = DW'(mr[k % NN]);
      mat_im = DW'(mi[k % NN]);
      if (gaps) begin
        start = 1'($urandom_range(0, 1));
        vec_valid = 1'b1;
        vec_re = DW'($urandom);
        vec_im = DW'($urandom);
      end else begin
        vec_valid = 1'b0;
      end
      #1;
      chk(done == prev_last, "R8", "done timing", done, prev_last);
      if (pend) begin
        chk(out_valid && out_re == h_re && out_im == h_im && out_idx == h_idx,
            "R7", "held result", {out_valid, out_re}, {1'b1, h_re});
      end
      if (done) begin
        seen_done = 1'b1;
        if (chk_lat) chk(cyc - c0 == N + NN + 2, "R9", "latency", cyc - c0, N + NN + 2);
      end
      prev_last = 1'b0;
      pend = out_valid && !out_ready;
      if (pend) begin
        h_re = out_re; h_im = out_im; h_idx = out_idx;
        chk(!mat_ready, "R7", "mat_ready while pending", mat_ready, 0);
      end
      if (out_valid && out_ready) begin
        chk(int'(out_idx) == eo, "R4", "out index", out_idx, eo);
        if (eo < N) begin
          chk(int'($signed(out_re)) == exp_re(eo), "R2,R6", "real part",
              $signed(out_re), exp_re(eo));
          chk(int'($signed(out_im)) == exp_im(eo), "R3,R6", "imag part",
              $signed(out_im), exp_im(eo));
        end
        if (eo == N - 1) prev_last = 1'b1;
        eo++;
      end
      if (mat_valid && mat_ready) k++;
      @(negedge clk);
    end
    start = 1'b0;
    vec_valid = 1'b0;
    mat_valid = 1'b0;
    chk(seen_done, "R8", "done seen", seen_done, 1);
    chk(eo == N, "R4", "result count", eo, N);
    chk(k == NN, "R4", "matrix elements taken", k, NN);
    #1;
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(out_valid == 1'b0 && done == 1'b0 && mat_ready == 1'b0, "R11",
        "reset outputs", {out_valid, done, mat_ready}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0 && mat_ready == 1'b0, "R11",
        "idle after reset", {out_valid, done, mat_ready}, 0);

    // identity matrix: checks pairing, order and latency (R1 R4 R9)
    for (int j = 0; j < N; j++) begin vr[j] = rval(0); vi[j] = rval(0); end
    for (int e = 0; e < NN; e++) begin
      mr[e] = (e / N == e % N) ? 16384 : 0;
      mi[e] = 0;
    end
    run_case(1'b0, 1'b1);

    // saturation in both directions (R5)
    for (int j = 0; j < N; j++) begin vr[j] = 32767; vi[j] = 0; end
    for (int e = 0; e < NN; e++) begin mr[e] = 32767; mi[e] = -32768; end
    run_case(1'b0, 1'b0);

    // half values: 1 -> 1, -1 -> 0, 3 -> 2, -3 -> -1 (R5)
    vr[0] = 1; vr[1] = -1; vr[2] = 3; vr[3] = -3;
    for (int j = 0; j < N; j++) vi[j] = vr[j];
    for (int e = 0; e < NN; e++) begin
      mr[e] = (e / N == e % N) ? 8192 : 0;
      mi[e] = 0;
    end
    run_case(1'b1, 1'b0);

    // random runs with stalls, back-pressure, spurious strobes (R1 R6 R7 R10)
    for (int r = 0; r < 8; r++) begin
      for (int j = 0; j < N; j++) begin vr[j] = rval(r % 3); vi[j] = rval(r % 3); end
      for (int e = 0; e < NN; e++) begin mr[e] = rval(r % 3); mi[e] = rval(r % 3); end
      run_case(r != 7, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule